// File: doc/BRIEF.md
# SPI Hold Condition Gate

This block sits between the pins of a mode 0/3 SPI slave and the slave's shift logic. It can pause a transfer while the active-low hold pin is asserted, and the device stays selected throughout. All four SPI pins are brought into a fast system clock with multi-flop synchronisers. Edges of the serial clock and of chip select are detected from the synchronised values.

The shift logic receives the following from the block:
- a one-cycle strobe for each serial-clock rising edge (sample) and each falling edge (launch);
- the qualified data-in bit;
- an output enable for its data-out tristate;
- a one-cycle interface reset when chip select rises.

Entering or leaving the paused state only happens while the serial clock is low. If hold changes while the clock is high, the change waits for the clock to go low. The output enable drops as soon as hold is seen low, without waiting for the clock. A self-timed write or erase in the shift logic is never touched: the block only gates strobes and the output enable. A `held` status output lets a user or bench see the paused state.

Top module: `spi_hold_gate`

## Requirements
- R1: While reset is applied, and after reset with chip select high, `shift_en`, `fall_en`, `held`, `dout_oe` and `logic_rst` are all 0.
- R2: With chip select low and no hold, each serial-clock rising edge gives exactly one `shift_en` pulse, carrying the pin's data bit on `din_q` in the same cycle. Each falling edge gives one `fall_en` pulse. Bits are taken in the order they arrive.
- R3: With chip select low and the serial clock low, hold driven low sets `held` within SYNC_STAGES+1 cycles. While `held` is 1, no `shift_en` or `fall_en` pulse occurs and `din_q` is 0, so data-in toggles are not captured.
- R4: Hold driven low while the serial clock is high does not set `held`. `held` is set only after the clock goes low, and the falling edge that ends that high phase still gives its `fall_en` pulse.
- R5: Hold returning high while the serial clock is low clears `held`. If the clock is high at that moment, `held` stays 1 until the clock goes low, and that falling edge gives no pulse.
- R6: `dout_oe` follows `so_drive_req` only while chip select is low, hold is seen high and `held` is 0. It drops within SYNC_STAGES cycles of hold going low, even before `held` is set, and it returns once `held` clears.
- R7: Each rise of chip select gives a one-cycle `logic_rst` pulse and clears `held`, including when it happens during a hold.
- R8: While chip select is high, hold low has no effect: `held` stays 0.
- R9: Chip select falling while hold is already low and the serial clock is low sets `held` with no shift pulse. Traffic resumes only after hold returns high.
- R10: While chip select is high, serial-clock edges give no `shift_en` or `fall_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sclk_pin | input | 1 | Serial clock pin |
| mosi_pin | input | 1 | Serial data-in pin |
| hold_n_pin | input | 1 | Hold pin, active low |
| so_drive_req | input | 1 | Shift logic wants to drive data-out |
| shift_en | output | 1 | One-cycle strobe per accepted rising edge |
| fall_en | output | 1 | One-cycle strobe per accepted falling edge |
| din_q | output | 1 | Qualified data-in, valid with `shift_en` |
| dout_oe | output | 1 | Output enable for the data-out tristate |
| logic_rst | output | 1 | One-cycle interface reset on chip-select rise |
| held | output | 1 | Hold state active |

## Verification
The delicate cycle is the one where the serial clock falls while a hold change is pending, because the same falling edge both completes the deferred hold change and is, or is not, a shift strobe. The bench provokes both directions:
- Hold is dropped during a high phase, so the falling edge must still be counted and `held` must follow one cycle later.
- Hold is released during a high phase, so the falling edge must clear `held` and must not be counted.

In both cases the test is judged from the edge counts (always eight falls and eight rises per byte) and from the captured byte. Garbage data is driven during the hold, so any leak changes the captured value. A second collision, chip select rising while `held` is 1, is judged by one reset pulse and `held` clearing.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

   // Minimum synchroniser depth accepted at elaboration
   localparam int unsigned HG_MIN_SYNC = 2;

   // Order of the synchronised pin vector
   localparam int unsigned HG_IDX_CS   = 0;
   localparam int unsigned HG_IDX_SCLK = 1;
   localparam int unsigned HG_IDX_MOSI = 2;
   localparam int unsigned HG_IDX_HOLD = 3;
   localparam int unsigned HG_NPINS    = 4;

   // Reset (idle) value of each pin after synchronisation
   localparam logic [HG_NPINS-1:0] HG_PIN_IDLE = 4'b1001; // hold=1, mosi=0, sclk=0, cs=1

   typedef enum logic {
      HG_RUN  = 1'b0,
      HG_HOLD = 1'b1
   } hg_state_e;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int unsigned          WIDTH   = 4,
   parameter int unsigned          STAGES  = 2,
   parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("spi_hold_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q_o = chain_q[LAST];

endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
   parameter int unsigned      WIDTH   = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= lvl_i;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      assign rise_o[b] =  lvl_i[b] & ~prev_q[b];
      assign fall_o[b] = ~lvl_i[b] &  prev_q[b];
   end

endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,     // synchronised chip select, active low
   input  logic sclk_s,   // synchronised serial clock
   input  logic hold_s,   // synchronised hold, active low
   output logic held_o
);

   hg_state_e state_q;

   // Entry and exit are both qualified by a low serial clock; a change
   // seen while the clock is high simply waits in the current state.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= HG_RUN;
      end else if (cs_s) begin
         state_q <= HG_RUN;
      end else begin
         unique case (state_q)
            HG_RUN:  if (!hold_s && !sclk_s) state_q <= HG_HOLD;
            HG_HOLD: if ( hold_s && !sclk_s) state_q <= HG_RUN;
            default: state_q <= HG_RUN;
         endcase
      end
   end

   assign held_o = (state_q == HG_HOLD);

endmodule

// File: rtl/spi_hold_qual.sv
module spi_hold_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_s,
   input  logic cs_rise,
   input  logic sclk_rise,
   input  logic sclk_fall,
   input  logic mosi_s,
   input  logic hold_s,
   input  logic held,
   input  logic so_drive_req,
   output logic shift_en,
   output logic fall_en,
   output logic din_q,
   output logic dout_oe,
   output logic logic_rst
);

   logic pass;
   logic rst_q;

   assign pass      = ~cs_s & ~held;
   assign shift_en  = sclk_rise & pass;
   assign fall_en   = sclk_fall & pass;
   assign din_q     = mosi_s & pass;
   // Output is released at once on a low hold, without clock qualification
   assign dout_oe   = so_drive_req & pass & hold_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b0;
      else        rst_q <= cs_rise;
   end

   assign logic_rst = rst_q;

endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate
   import spi_hold_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_pin,
   input  logic sclk_pin,
   input  logic mosi_pin,
   input  logic hold_n_pin,
   input  logic so_drive_req,
   output logic shift_en,
   output logic fall_en,
   output logic din_q,
   output logic dout_oe,
   output logic logic_rst,
   output logic held
);

   localparam logic [1:0] EDGE_IDLE = {HG_PIN_IDLE[HG_IDX_SCLK], HG_PIN_IDLE[HG_IDX_CS]};

   generate
      if (SYNC_STAGES < HG_MIN_SYNC) begin : g_bad_sync
         $error("spi_hold_gate: SYNC_STAGES below minimum");
      end
   endgenerate

   logic [HG_NPINS-1:0] pins_raw;
   logic [HG_NPINS-1:0] pins_s;
   logic                cs_s, sclk_s, mosi_s, hold_s;
   logic [1:0]          edge_rise, edge_fall;

   always_comb begin
      pins_raw              = '0;
      pins_raw[HG_IDX_CS]   = cs_n_pin;
      pins_raw[HG_IDX_SCLK] = sclk_pin;
      pins_raw[HG_IDX_MOSI] = mosi_pin;
      pins_raw[HG_IDX_HOLD] = hold_n_pin;
   end

   spi_hold_sync #(
      .WIDTH   (HG_NPINS),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (HG_PIN_IDLE)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_raw),
      .q_o   (pins_s)
   );

   assign cs_s   = pins_s[HG_IDX_CS];
   assign sclk_s = pins_s[HG_IDX_SCLK];
   assign mosi_s = pins_s[HG_IDX_MOSI];
   assign hold_s = pins_s[HG_IDX_HOLD];

   spi_hold_edge #(
      .WIDTH   (2),
      .RST_VAL (EDGE_IDLE)
   ) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({sclk_s, cs_s}),
      .rise_o (edge_rise),
      .fall_o (edge_fall)
   );

   spi_hold_fsm fsm_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .cs_s   (cs_s),
      .sclk_s (sclk_s),
      .hold_s (hold_s),
      .held_o (held)
   );

   spi_hold_qual qual_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_s         (cs_s),
      .cs_rise      (edge_rise[0]),
      .sclk_rise    (edge_rise[1]),
      .sclk_fall    (edge_fall[1]),
      .mosi_s       (mosi_s),
      .hold_s       (hold_s),
      .held         (held),
      .so_drive_req (so_drive_req),
      .shift_en     (shift_en),
      .fall_en      (fall_en),
      .din_q        (din_q),
      .dout_oe      (dout_oe),
      .logic_rst    (logic_rst)
   );

   logic unused_fall_cs;
   assign unused_fall_cs = edge_fall[0];

endmodule

// File: rtl/spi_hold_gate_chk.sv
module spi_hold_gate_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_s,
   input logic sclk_s,
   input logic hold_s,
   input logic held,
   input logic shift_en,
   input logic fall_en,
   input logic dout_oe,
   input logic logic_rst
);

   AST_HOLD_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !cs_s && !hold_s && !sclk_s) |=> held);                 // R3

   AST_HOLD_WAIT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && !cs_s && sclk_s) |=> !held);                            // R4

   AST_HOLD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !cs_s && hold_s && !sclk_s) |=> !held);                  // R5

   AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (held && !cs_s && sclk_s) |=> held);                              // R5

   AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_s || held) |-> !dout_oe);                                  // R6

   AST_CS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_s) |=> (logic_rst && !held));                            // R7

   AST_DESEL_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !held);                                                  // R8

   AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |-> (!shift_en && !fall_en));                                // R10

endmodule

bind spi_hold_gate spi_hold_gate_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_s      (cs_s),
   .sclk_s    (sclk_s),
   .hold_s    (hold_s),
   .held      (held),
   .shift_en  (shift_en),
   .fall_en   (fall_en),
   .dout_oe   (dout_oe),
   .logic_rst (logic_rst)
);

// File: tb/spi_hold_gate_tb.sv
module spi_hold_gate_tb_top;

   logic clk = 1'b0;
   logic rst_n;
   logic cs_n, sclk, mosi, hold_n, so_req;
   logic shift_en, fall_en, din_q, dout_oe, logic_rst, held;

   always #2 clk = ~clk; // 250 MHz

   spi_hold_gate #(.SYNC_STAGES(2)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_n_pin     (cs_n),
      .sclk_pin     (sclk),
      .mosi_pin     (mosi),
      .hold_n_pin   (hold_n),
      .so_drive_req (so_req),
      .shift_en     (shift_en),
      .fall_en      (fall_en),
      .din_q        (din_q),
      .dout_oe      (dout_oe),
      .logic_rst    (logic_rst),
      .held         (held)
   );

   // data, hold-before-bit, drop-while-high, release-while-high, pad, garbage pulses
   localparam logic [19:0] VEC [6] = '{
      {8'hA5, 4'd3, 1'b0, 1'b0, 2'b00, 4'd2},
      {8'h3C, 4'd5, 1'b1, 1'b0, 2'b00, 4'd3},
      {8'hF0, 4'd1, 1'b0, 1'b1, 2'b00, 4'd1},
      {8'h0F, 4'd7, 1'b1, 1'b1, 2'b00, 4'd4},
      {8'h81, 4'd4, 1'b0, 1'b0, 2'b00, 4'd0},
      {8'h5A, 4'd2, 1'b1, 1'b1, 2'b00, 4'd2}
   };

   int checks = 0;
   int failures = 0;
   int shift_cnt = 0, fall_cnt = 0, rst_cnt = 0;
   logic [7:0] cap = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (shift_en) begin
            shift_cnt <= shift_cnt + 1;
            cap <= {cap[6:0], din_q};
         end
         if (fall_en)   fall_cnt <= fall_cnt + 1;
         if (logic_rst) rst_cnt  <= rst_cnt + 1;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic pulse_sclk(input int n);
      for (int j = 0; j < n; j++) begin
         mosi = ~mosi; wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
      end
   endtask

   logic [7:0] d;
   int k, g, s0, f0, r0, m0;
   logic ehi, xhi;

   task automatic hold_section();
      if (!ehi) begin
         hold_n = 1'b0; wait_n(6);
      end
      chk("R3 held set", held, 1);
      chk("R6 oe off in hold", dout_oe, 0);
      m0 = shift_cnt;
      for (int j = 0; j < g; j++) begin
         mosi = ~mosi; wait_n(4); sclk = 1'b1; wait_n(4);
         if (xhi && j == g - 1) begin
            hold_n = 1'b1; wait_n(6);
            chk("R5 exit deferred, clk high", held, 1);
            chk("R6 oe stays off until exit", dout_oe, 0);
         end
         sclk = 1'b0; wait_n(4);
      end
      hold_n = 1'b1; wait_n(6);
      chk("R5 held cleared", held, 0);
      chk("R6 oe back", dout_oe, 1);
      chk("R3 no shift in hold", shift_cnt - m0, 0);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0; hold_n = 1'b1; so_req = 1'b1;
      wait_n(5);
      chk("R1 shift_en in reset", shift_en, 0);
      chk("R1 fall_en in reset", fall_en, 0);
      chk("R1 held in reset", held, 0);
      chk("R1 oe in reset", dout_oe, 0);
      chk("R1 rst pulse in reset", logic_rst, 0);
      rst_n = 1'b1; wait_n(6);
      chk("R1 held after reset", held, 0);
      chk("R1 oe after reset, deselected", dout_oe, 0);

      for (int v = 0; v < 6; v++) begin
         d = VEC[v][19:12]; k = int'(VEC[v][11:8]); ehi = VEC[v][7];
         xhi = VEC[v][6]; g = int'(VEC[v][3:0]);
         s0 = shift_cnt; f0 = fall_cnt; r0 = rst_cnt;
         cs_n = 1'b0; wait_n(6);
         for (int n = 0; n < 8; n++) begin
            mosi = d[7-n]; wait_n(4); sclk = 1'b1; wait_n(4);
            if (ehi && n == k - 1) begin
               hold_n = 1'b0; wait_n(6);
               chk("R4 entry deferred, clk high", held, 0);
               chk("R6 oe off before held", dout_oe, 0);
            end
            sclk = 1'b0; wait_n(4);
            if (n == k - 1) hold_section();
         end
         wait_n(4);
         chk("R2 rising strobes", shift_cnt - s0, 8);
         chk("R2 captured byte", int'(cap), int'(d));
         chk("R4 falling strobes incl. deferred entry", fall_cnt - f0, 8);
         cs_n = 1'b1; wait_n(6);
         chk("R7 reset pulse at deselect", rst_cnt - r0, 1);
      end

      // R8 and R10: deselected, hold low and clock pulses
      hold_n = 1'b0; wait_n(6);
      chk("R8 hold ignored when deselected", held, 0);
      s0 = shift_cnt; f0 = fall_cnt;
      pulse_sclk(3);
      chk("R10 no rising strobe deselected", shift_cnt - s0, 0);
      chk("R10 no falling strobe deselected", fall_cnt - f0, 0);

      // R9: select while hold already low
      cs_n = 1'b0; wait_n(6);
      chk("R9 held on select with hold low", held, 1);
      pulse_sclk(2);
      chk("R9 no strobe while held", shift_cnt - s0, 0);

      // R7: deselect in the middle of a hold
      r0 = rst_cnt;
      cs_n = 1'b1; wait_n(6);
      chk("R7 reset pulse during hold", rst_cnt - r0, 1);
      chk("R7 held cleared", held, 0);

      // R9: resume after hold returns high
      hold_n = 1'b1; cs_n = 1'b0; wait_n(6);
      s0 = shift_cnt;
      d = 8'hC3;
      for (int n = 0; n < 8; n++) begin
         mosi = d[7-n]; wait_n(4); sclk = 1'b1; wait_n(4); sclk = 1'b0; wait_n(4);
      end
      chk("R9 resume count", shift_cnt - s0, 8);
      chk("R2 byte after resume", int'(cap), int'(d));
      cs_n = 1'b1; wait_n(6);

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

endmodule